// File: doc/BRIEF.md
# Last-Value Result Predictor with Confidence Hysteresis

This block keeps a small direct-mapped table that guesses an instruction's result will repeat the value that instruction produced the previous time. A lookup port takes an instruction address and, in the same cycle, returns the stored value together with a flag that says whether the prediction is trustworthy. An update port takes the address and the committed result of a retiring instruction and trains the entry.

Each entry holds a valid bit, a short partial tag taken from the address, the remembered value and a small saturating confidence counter. A correct result raises the counter and a wrong one lowers it. A stored value that has proven stable survives an occasional odd result, because the value is only overwritten once confidence has dropped under the threshold. Only instructions that write a register train the table. Stores, branches and jumps present themselves with the register-write flag low and are ignored.

Top module: `lastval_pred`

## Requirements
- R1: After reset every entry is invalid and has a zero counter, so a lookup of any address returns hit = 0.
- R2: Address bits [7:2] select one of 64 entries and bits [11:8] form a 4-bit partial tag. A lookup whose tag differs from the stored tag returns hit = 0.
- R3: A trained update that finds its entry invalid or holding a different tag writes the result, the new tag and valid = 1, and sets the counter to 0.
- R4: A trained update whose tag matches and whose result equals the stored value increments the 2-bit counter, which saturates at 3.
- R5: A trained update whose tag matches, whose result differs and whose counter is 2 or 3 keeps the stored value and decrements the counter.
- R6: A trained update whose tag matches, whose result differs and whose counter is 0 or 1 replaces the stored value with the result and sets the counter to 0.
- R7: The lookup returns hit = 1 exactly when the entry is valid, the tag matches and the counter is at least 2, and it then presents the stored value. Both outputs respond combinationally in the cycle the address is presented.
- R8: An update with `up_wr_reg` = 0 (store, branch or jump) or with `up_en` = 0 changes no entry.
- R9: A lookup and an update to the same entry in the same cycle return the contents from before the update. The update becomes visible from the cycle after the clock edge that accepts it.
- R10: Training one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears valid bits and counters |
| lk_pc | input | 32 | Instruction address to predict for |
| lk_hit | output | 1 | Prediction is confident and tag-matched |
| lk_value | output | 32 | Predicted result (meaningful when lk_hit = 1) |
| up_en | input | 1 | An instruction is retiring this cycle |
| up_wr_reg | input | 1 | The retiring instruction writes a register |
| up_pc | input | 32 | Address of the retiring instruction |
| up_result | input | 32 | Committed result of the retiring instruction |

## Verification
Lookup results are due in the same cycle as the address, so the bench presents `lk_pc` after a falling edge and samples one nanosecond later, with no clock edge in between. An update is accepted at the single rising edge that follows its drive at a falling edge, and its effect is checked by a lookup in the next low phase. The same-cycle case is checked twice: once before the accepting edge, where the lookup must show the old entry, and once just after it, where it must show the new one. Each counter step (allocate, strengthen, saturate, weaken, replace) is followed by its own lookup, so the hit flag shows where the counter sits relative to the threshold.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

   // What a trained update does to its entry
   typedef enum logic [1:0] {
      ACT_ALLOC      = 2'd0,
      ACT_STRENGTHEN = 2'd1,
      ACT_WEAKEN     = 2'd2,
      ACT_REPLACE    = 2'd3
   } lvp_act_e;

endpackage

// File: rtl/lvp_addr_split.sv
module lvp_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 4,
   localparam int TAG_BITS = (TAG_W > 0) ? TAG_W : 1
) (
   input  logic [ADDR_W-1:0]   pc,
   output logic [IDX_W-1:0]    idx,
   output logic [TAG_BITS-1:0] tag
);

   generate
      if (IDX_LSB + IDX_W + TAG_W > ADDR_W) begin : g_bad_split
         $error("lvp_addr_split: index and tag do not fit in the address");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("lvp_addr_split: IDX_W must be at least 1");
      end
   endgenerate

   assign idx = pc[IDX_LSB +: IDX_W];

   generate
      if (TAG_W > 0) begin : g_tag
         assign tag = pc[IDX_LSB + IDX_W +: TAG_W];
      end else begin : g_notag
         assign tag = '0;
      end
   endgenerate

endmodule

// File: rtl/lvp_train_ctl.sv
module lvp_train_ctl
   import lvp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int TAG_BITS = 4,
   parameter int CNT_W    = 2,
   parameter int THRESH   = 2
) (
   input  logic                ent_valid,
   input  logic [TAG_BITS-1:0] ent_tag,
   input  logic [CNT_W-1:0]    ent_cnt,
   input  logic [DATA_W-1:0]   ent_value,
   input  logic [TAG_BITS-1:0] in_tag,
   input  logic [DATA_W-1:0]   in_result,
   output lvp_act_e            act,
   output logic [CNT_W-1:0]    nxt_cnt,
   output logic [DATA_W-1:0]   nxt_value
);

   localparam int               CNT_MAX_I = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(CNT_MAX_I);
   localparam logic [CNT_W-1:0] THR       = CNT_W'(THRESH);

   generate
      if (THRESH < 1 || THRESH > CNT_MAX_I) begin : g_bad_thr
         $error("lvp_train_ctl: THRESH must lie in 1 .. 2**CNT_W-1");
      end
   endgenerate

   logic tag_ok;
   logic same;

   assign tag_ok = ent_valid && (ent_tag == in_tag);
   assign same   = (ent_value == in_result);

   always_comb begin
      if (!tag_ok) begin
         act       = ACT_ALLOC;
         nxt_cnt   = '0;
         nxt_value = in_result;
      end else if (same) begin
         act       = ACT_STRENGTHEN;
         nxt_cnt   = (ent_cnt == CNT_MAX) ? ent_cnt : ent_cnt + 1'b1;
         nxt_value = ent_value;
      end else if (ent_cnt >= THR) begin
         act       = ACT_WEAKEN;
         nxt_cnt   = ent_cnt - 1'b1;
         nxt_value = ent_value;
      end else begin
         act       = ACT_REPLACE;
         nxt_cnt   = '0;
         nxt_value = in_result;
      end
   end

endmodule

// File: rtl/lvp_table.sv
module lvp_table #(
   parameter int IDX_W    = 6,
   parameter int TAG_BITS = 4,
   parameter int CNT_W    = 2,
   parameter int DATA_W   = 32,
   localparam int DEPTH   = 1 << IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   // read port A (lookup)
   input  logic [IDX_W-1:0]    a_idx,
   output logic                a_valid,
   output logic [TAG_BITS-1:0] a_tag,
   output logic [CNT_W-1:0]    a_cnt,
   output logic [DATA_W-1:0]   a_value,
   // read port B (training)
   input  logic [IDX_W-1:0]    b_idx,
   output logic                b_valid,
   output logic [TAG_BITS-1:0] b_tag,
   output logic [CNT_W-1:0]    b_cnt,
   output logic [DATA_W-1:0]   b_value,
   // write port
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [TAG_BITS-1:0] wr_tag,
   input  logic [CNT_W-1:0]    wr_cnt,
   input  logic [DATA_W-1:0]   wr_value
);

   generate
      if (DEPTH > 4096) begin : g_bad_depth
         $error("lvp_table: table deeper than 4096 entries");
      end
   endgenerate

   logic                valid_q [DEPTH];
   logic [CNT_W-1:0]    cnt_q   [DEPTH];
   logic [TAG_BITS-1:0] tag_q   [DEPTH];
   logic [DATA_W-1:0]   val_q   [DEPTH];

   // control state: cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            valid_q[i] <= 1'b0;
            cnt_q[i]   <= '0;
         end
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         cnt_q[wr_idx]   <= wr_cnt;
      end
   end

   // payload: qualified by valid, no reset needed
   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         val_q[wr_idx] <= wr_value;
      end
   end

   assign a_valid = valid_q[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_cnt   = cnt_q[a_idx];
   assign a_value = val_q[a_idx];

   assign b_valid = valid_q[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_cnt   = cnt_q[b_idx];
   assign b_value = val_q[b_idx];

endmodule

// File: rtl/lastval_pred.sv
module lastval_pred
   import lvp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 4,
   parameter int CNT_W   = 2,
   parameter int THRESH  = 2,
   localparam int TAG_BITS = (TAG_W > 0) ? TAG_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_value,
   input  logic              up_en,
   input  logic              up_wr_reg,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic [DATA_W-1:0] up_result
);

   localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

   logic [IDX_W-1:0]    lk_idx, up_idx;
   logic [TAG_BITS-1:0] lk_tag, up_tag;

   logic                lk_ent_valid, up_ent_valid;
   logic [TAG_BITS-1:0] lk_ent_tag,   up_ent_tag;
   logic [CNT_W-1:0]    lk_ent_cnt,   up_ent_cnt;
   logic [DATA_W-1:0]   lk_ent_value, up_ent_value;

   lvp_act_e            upd_act;
   logic [CNT_W-1:0]    wr_cnt;
   logic [DATA_W-1:0]   wr_value;
   logic                train;

   lvp_addr_split #(
      .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_lk_split (
      .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
   );

   lvp_addr_split #(
      .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_up_split (
      .pc(up_pc), .idx(up_idx), .tag(up_tag)
   );

   lvp_table #(
      .IDX_W(IDX_W), .TAG_BITS(TAG_BITS), .CNT_W(CNT_W), .DATA_W(DATA_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_idx    (lk_idx),
      .a_valid  (lk_ent_valid),
      .a_tag    (lk_ent_tag),
      .a_cnt    (lk_ent_cnt),
      .a_value  (lk_ent_value),
      .b_idx    (up_idx),
      .b_valid  (up_ent_valid),
      .b_tag    (up_ent_tag),
      .b_cnt    (up_ent_cnt),
      .b_value  (up_ent_value),
      .wr_en    (train),
      .wr_idx   (up_idx),
      .wr_tag   (up_tag),
      .wr_cnt   (wr_cnt),
      .wr_value (wr_value)
   );

   lvp_train_ctl #(
      .DATA_W(DATA_W), .TAG_BITS(TAG_BITS), .CNT_W(CNT_W), .THRESH(THRESH)
   ) u_ctl (
      .ent_valid (up_ent_valid),
      .ent_tag   (up_ent_tag),
      .ent_cnt   (up_ent_cnt),
      .ent_value (up_ent_value),
      .in_tag    (up_tag),
      .in_result (up_result),
      .act       (upd_act),
      .nxt_cnt   (wr_cnt),
      .nxt_value (wr_value)
   );

   // only register-writing instructions train the table
   assign train = up_en && up_wr_reg;

   assign lk_hit   = lk_ent_valid && (lk_ent_tag == lk_tag) && (lk_ent_cnt >= THR);
   assign lk_value = lk_ent_value;

endmodule

// File: rtl/lvp_chk.sv
module lvp_chk
   import lvp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lk_pc,
   input logic              lk_hit,
   input logic [DATA_W-1:0] lk_value,
   input logic              up_en,
   input logic              up_wr_reg,
   input lvp_act_e          act,
   input logic [DATA_W-1:0] ent_value,
   input logic [DATA_W-1:0] wr_value,
   input logic [CNT_W-1:0]  wr_cnt
);

   logic       trained;
   logic [1:0] seen_q;

   assign trained = up_en && up_wr_reg;

   // trained updates since reset, saturating at 3
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        seen_q <= 2'd0;
      else if (trained && seen_q != 2'd3) seen_q <= seen_q + 2'd1;
   end

   // R1: nothing predicted right after reset
   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !lk_hit);

   // R7: a confident hit needs allocation plus two confirmations first
   a_r7_hit_needs_training: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> seen_q == 2'd3);

   // R8: without a trained update a held lookup keeps its answer
   a_r8_untrained_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!trained) && $stable(lk_pc)) |-> ($stable(lk_hit) && (!lk_hit || $stable(lk_value))));

   // R5: a confident mismatch keeps the stored value
   a_r5_weaken_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
      (trained && act == ACT_WEAKEN) |-> wr_value == ent_value);

   // R6 (and R3): whenever a new value is written, confidence restarts at zero
   a_r6_new_value_zero_conf: assert property (@(posedge clk) disable iff (!rst_n)
      (trained && wr_value != ent_value) |-> wr_cnt == '0);

endmodule

bind lastval_pred lvp_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_pc     (lk_pc),
   .lk_hit    (lk_hit),
   .lk_value  (lk_value),
   .up_en     (up_en),
   .up_wr_reg (up_wr_reg),
   .act       (upd_act),
   .ent_value (up_ent_value),
   .wr_value  (wr_value),
   .wr_cnt    (wr_cnt)
);

// File: tb/tb_lastval_pred.sv
`timescale 1ns/1ps
module tb_lastval_pred;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_value;
   logic        up_en = 1'b0;
   logic        up_wr_reg = 1'b0;
   logic [31:0] up_pc = '0;
   logic [31:0] up_result = '0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lastval_pred dut (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_value(lk_value),
      .up_en(up_en), .up_wr_reg(up_wr_reg), .up_pc(up_pc), .up_result(up_result)
   );

   localparam logic [31:0] PC_A  = 32'h0000_0104; // idx 1, tag 1
   localparam logic [31:0] PC_AL = 32'h0000_0204; // idx 1, tag 2
   localparam logic [31:0] PC_B  = 32'h0000_03A8; // idx 42, tag 3
   localparam logic [31:0] PC_C  = 32'h0000_00FC; // idx 63, tag 0
   localparam logic [31:0] PC_D  = 32'h0000_00F8; // idx 62, tag 0

   // one update accepted at the next rising edge
   task automatic upd(input logic [31:0] pc, input logic [31:0] res,
                      input logic en, input logic wr);
      @(negedge clk);
      up_en = en; up_wr_reg = wr; up_pc = pc; up_result = res;
      @(negedge clk);
      up_en = 1'b0; up_wr_reg = 1'b0;
   endtask

   // lookup in the low phase, compare one ns later
   task automatic look(input logic [31:0] pc, input logic exp_hit,
                       input logic [31:0] exp_val, input string req);
      lk_pc = pc;
      #1;
      n_chk++;
      if (lk_hit !== exp_hit || (exp_hit && lk_value !== exp_val)) begin
         n_fail++;
         $display("FAIL %s: hit=%0b value=%h expected hit=%0b value=%h",
                  req, lk_hit, lk_value, exp_hit, exp_val);
      end
   endtask

   task automatic t_reset;
      look(PC_A, 1'b0, 32'h0, "R1 idx1");
      look(PC_C, 1'b0, 32'h0, "R1 idx63");
      look(32'h0, 1'b0, 32'h0, "R1 idx0");
   endtask

   task automatic t_warmup;
      upd(PC_A, 32'h55, 1'b1, 1'b1);
      look(PC_A, 1'b0, 32'h0, "R3 alloc cnt0");
      upd(PC_A, 32'h55, 1'b1, 1'b1);
      look(PC_A, 1'b0, 32'h0, "R4 cnt1 below threshold");
      upd(PC_A, 32'h55, 1'b1, 1'b1);
      look(PC_A, 1'b1, 32'h55, "R7 cnt2 hit");
   endtask

   task automatic t_hysteresis;
      upd(PC_A, 32'h55, 1'b1, 1'b1);           // cnt 3
      upd(PC_A, 32'h55, 1'b1, 1'b1);           // saturates at 3
      upd(PC_A, 32'h77, 1'b1, 1'b1);           // 3 -> 2
      look(PC_A, 1'b1, 32'h55, "R4 saturated then R5 weaken keeps value");
      upd(PC_A, 32'h77, 1'b1, 1'b1);           // 2 -> 1
      look(PC_A, 1'b0, 32'h0, "R5 weaken to cnt1");
      upd(PC_A, 32'h77, 1'b1, 1'b1);           // replace, cnt 0
      look(PC_A, 1'b0, 32'h0, "R6 replace cnt0");
      upd(PC_A, 32'h77, 1'b1, 1'b1);
      upd(PC_A, 32'h77, 1'b1, 1'b1);
      look(PC_A, 1'b1, 32'h77, "R6 replaced value predicted");
   endtask

   task automatic t_untrained;
      upd(PC_A, 32'hDEAD, 1'b1, 1'b0);
      upd(PC_A, 32'hDEAD, 1'b1, 1'b0);
      upd(PC_A, 32'hDEAD, 1'b1, 1'b0);
      look(PC_A, 1'b1, 32'h77, "R8 no register write");
      upd(PC_A, 32'hBEEF, 1'b0, 1'b1);
      upd(PC_A, 32'hBEEF, 1'b0, 1'b1);
      upd(PC_A, 32'hBEEF, 1'b0, 1'b1);
      look(PC_A, 1'b1, 32'h77, "R8 update disabled");
   endtask

   task automatic t_alias;
      look(PC_AL, 1'b0, 32'h0, "R2 tag mismatch");
      upd(PC_AL, 32'h99, 1'b1, 1'b1);
      upd(PC_AL, 32'h99, 1'b1, 1'b1);
      upd(PC_AL, 32'h99, 1'b1, 1'b1);
      look(PC_AL, 1'b1, 32'h99, "R3 realloc on tag change");
      look(PC_A, 1'b0, 32'h0, "R2 old tag evicted");
   endtask

   task automatic t_same_cycle;
      upd(PC_B, 32'h1234, 1'b1, 1'b1);
      upd(PC_B, 32'h1234, 1'b1, 1'b1);
      upd(PC_B, 32'h1234, 1'b1, 1'b1);      // cnt 2
      @(negedge clk);
      up_en = 1'b1; up_wr_reg = 1'b1; up_pc = PC_B; up_result = 32'h4321;
      look(PC_B, 1'b1, 32'h1234, "R9 pre-update contents");
      @(posedge clk);
      #1;
      look(PC_B, 1'b0, 32'h0, "R9 update visible next cycle");
      @(negedge clk);
      up_en = 1'b0; up_wr_reg = 1'b0;
   endtask

   task automatic t_independent;
      upd(PC_C, 32'hC0, 1'b1, 1'b1);
      upd(PC_C, 32'hC0, 1'b1, 1'b1);
      upd(PC_C, 32'hC0, 1'b1, 1'b1);
      look(PC_C, 1'b1, 32'hC0, "R10 top entry trained");
      look(PC_D, 1'b0, 32'h0, "R10 neighbour untouched");
      look(PC_AL, 1'b1, 32'h99, "R10 earlier entry kept");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_warmup;
      t_hysteresis;
      t_untrained;
      t_alias;
      t_same_cycle;
      t_independent;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule